// File: doc/BRIEF.md
# Two-Pipe Priority Layer Compositor

This block merges four rectangular image layers into a single RGB pixel stream, one raster position per clock. Composition happens in two stages. First, every layer is routed to one of two pipes. Inside each pipe, overlap is settled purely by priority, with no blending. Second, the pipe-1 winner is alpha-blended over the pipe-0 result, and the pipe-0 result is itself the pipe-0 winner blended over a background colour.

Each layer supplies one ARGB8888 pixel for the current raster coordinate, together with its own settings: enable, pipe, priority, rectangle, and global alpha. A raster source drives x/y and a pixel-valid strobe. A display size bounds the visible frame. A defect mode reproduces a known silicon fault: an alpha-carrying lowest layer of pipe 0 shows the background colour instead of its pixels.

Top module: `layer_compositor`

## Requirements
- R1: After reset, valid_o and rgb_o are 0 and the background colour is black (0x000000).
- R2: Layer i covers (x, y) only when it is enabled and lay_x <= x < lay_x + lay_w and lay_y <= y < lay_y + lay_h. A zero width or zero height covers nothing.
- R3: Within a pipe (lay_pipe_i bit 0 = pipe 0, 1 = pipe 1), the covering layer with the largest 2-bit priority supplies the pipe pixel. On equal priority, the higher layer index wins.
- R4: The output is mix(a1, p1, c0) per channel, where mix(a, f, b) = (a*f + (255-a)*b + 127)/255. Here p1 and a1 are the pipe-1 winner's colour and effective alpha, and c0 is the pipe-0 colour. With no pipe-1 winner, the output equals c0.
- R5: c0 is mix(a0, p0, bg) for the pipe-0 winner, where bg is the background colour. With no pipe-0 winner, c0 equals bg.
- R6: Layer pixels are ARGB8888: alpha in bits 31:24, red 23:16, green 15:8, blue 7:0. When a layer's global-alpha enable is set, its effective alpha is (pixel_alpha*global_alpha + 127)/255. Otherwise it is the pixel alpha.
- R7: When defect_mode_i is 1 and the pipe-0 winner has priority 0 and an effective alpha below 255, c0 is the background colour.
- R8: valid_o is 1 only for pixels with pix_valid_i = 1, x_i < disp_w_i and y_i < disp_h_i. rgb_o is 0 whenever valid_o is 0.
- R9: rgb_o and valid_o reflect the inputs presented exactly two rising clock edges earlier.
- R10: The background colour loads bg_rgb_i (red 23:16, green 15:8, blue 7:0) on a rising edge with bg_we_i = 1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| defect_mode_i | input | 1 | Enables lowest-layer alpha defect behaviour |
| bg_we_i | input | 1 | Background colour load strobe |
| bg_rgb_i | input | 24 | Background colour to load |
| disp_w_i | input | COORD_W | Output frame width |
| disp_h_i | input | COORD_W | Output frame height |
| lay_en_i | input | 4 | Per-layer enable |
| lay_pipe_i | input | 4 | Per-layer pipe select |
| lay_prio_i | input | 8 | Per-layer 2-bit priority, layer i at bits 2i+1:2i |
| lay_x_i | input | 4*COORD_W | Per-layer left edge |
| lay_y_i | input | 4*COORD_W | Per-layer top edge |
| lay_w_i | input | 4*COORD_W | Per-layer width |
| lay_h_i | input | 4*COORD_W | Per-layer height |
| lay_pix_i | input | 128 | Per-layer ARGB8888 pixel at current x/y |
| lay_ga_i | input | 32 | Per-layer global alpha |
| lay_ga_en_i | input | 4 | Per-layer global alpha enable |
| pix_valid_i | input | 1 | Current x/y is a real pixel |
| x_i | input | COORD_W | Raster x |
| y_i | input | COORD_W | Raster y |
| rgb_o | output | 24 | Composed pixel |
| valid_o | output | 1 | Composed pixel valid |

## Verification
Directed scenes place one layer at rectangle edges, which separates off-by-one coverage faults. They stack two layers in one pipe at distinct and equal priorities, which exposes a wrong comparison or a wrong tie direction. They also pair a translucent pipe-1 layer with an opaque pipe-0 layer, which distinguishes a blend direction swap from rounding errors. Defect mode is toggled against the same translucent lowest layer and an opaque one, so the replacement by background is seen to depend on alpha and mode alone. Random scenes with random priorities, pipes, rectangles and alphas are compared with a bench model of the requirements, covering mixed interactions the directed cases do not reach.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int NUM_LAYERS = 4;
  localparam int NUM_PIPES  = 2;
  localparam int PRIO_W     = 2;
  localparam int CH_W       = 8;
  localparam int RGB_W      = 3 * CH_W;
  localparam int PIX_W      = 4 * CH_W;
  localparam int IDX_W      = $clog2(NUM_LAYERS);
  localparam logic [CH_W-1:0] ALPHA_MAX = '1;

  typedef logic [RGB_W-1:0] rgb_t;

  // (a*f + (max-a)*b + max/2) / max, rounded
  function automatic logic [CH_W-1:0] mix_ch(input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] f,
                                             input logic [CH_W-1:0] b);
    localparam int AW = 2 * CH_W + 1;
    logic [AW-1:0] ax, fx, bx, acc;
    ax  = AW'(a);
    fx  = AW'(f);
    bx  = AW'(b);
    acc = ax * fx + (AW'(ALPHA_MAX) - ax) * bx + AW'(ALPHA_MAX >> 1);
    return CH_W'(acc / AW'(ALPHA_MAX));
  endfunction
endpackage

// File: rtl/layer_cover.sv
module layer_cover
  import comp_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               en_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] lx_i,
  input  logic [COORD_W-1:0] ly_i,
  input  logic [COORD_W-1:0] lw_i,
  input  logic [COORD_W-1:0] lh_i,
  input  logic [CH_W-1:0]    pix_alpha_i,
  input  logic [CH_W-1:0]    ga_i,
  input  logic               ga_en_i,
  output logic               hit_o,
  output logic [CH_W-1:0]    alpha_o
);
  localparam int EW = COORD_W + 1;

  logic [EW-1:0] x_end, y_end;
  logic          in_x, in_y;

  assign x_end = EW'(lx_i) + EW'(lw_i);
  assign y_end = EW'(ly_i) + EW'(lh_i);
  assign in_x  = (x_i >= lx_i) && (EW'(x_i) < x_end);
  assign in_y  = (y_i >= ly_i) && (EW'(y_i) < y_end);
  assign hit_o = en_i && in_x && in_y;

  assign alpha_o = ga_en_i ? mix_ch(ga_i, pix_alpha_i, '0) : pix_alpha_i;
endmodule

// File: rtl/pipe_arbiter.sv
module pipe_arbiter
  import comp_pkg::*;
#(
  parameter int PIPE_ID = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_LAYERS-1:0]        hit_i,
  input  logic [NUM_LAYERS-1:0]        pipe_i,
  input  logic [NUM_LAYERS*PRIO_W-1:0] prio_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            prio_o
);
  logic [NUM_LAYERS-1:0] cand;

  generate
    if (PIPE_ID == 0) begin : g_p0
      assign cand = hit_i & ~pipe_i;
    end else begin : g_p1
      assign cand = hit_i & pipe_i;
    end
  endgenerate

  // ascending scan with >= gives ties to the higher index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (cand[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int j = 0; j < NUM_LAYERS; j++) begin
      if (cand[j] && found_o &&
          ((prio_i[j*PRIO_W +: PRIO_W] > prio_o) ||
           (prio_i[j*PRIO_W +: PRIO_W] == prio_o && IDX_W'(j) > idx_o)))
        beaten = 1'b1;
    end
  end

  AST_WIN_COVERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (hit_i[idx_o] && pipe_i[idx_o] == 1'(PIPE_ID))); // R3
  AST_WIN_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beaten); // R3
  AST_FOUND_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == '0) |-> !found_o); // R2
endmodule

// File: rtl/blend_unit.sv
module blend_unit
  import comp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] alpha_i,
  input  rgb_t            fg_i,
  input  rgb_t            bg_i,
  output rgb_t            mix_o
);
  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CH_W-1:0] f, b, m, lo, hi;
    assign f  = fg_i[c*CH_W +: CH_W];
    assign b  = bg_i[c*CH_W +: CH_W];
    assign m  = mix_ch(alpha_i, f, b);
    assign mix_o[c*CH_W +: CH_W] = m;
    assign lo = (f < b) ? f : b;
    assign hi = (f < b) ? b : f;

    AST_MIX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m >= lo) && (m <= hi)); // R4
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             defect_mode_i,
  input  logic                             bg_we_i,
  input  logic [RGB_W-1:0]                 bg_rgb_i,
  input  logic [COORD_W-1:0]               disp_w_i,
  input  logic [COORD_W-1:0]               disp_h_i,
  input  logic [NUM_LAYERS-1:0]            lay_en_i,
  input  logic [NUM_LAYERS-1:0]            lay_pipe_i,
  input  logic [NUM_LAYERS*PRIO_W-1:0]     lay_prio_i,
  input  logic [NUM_LAYERS*COORD_W-1:0]    lay_x_i,
  input  logic [NUM_LAYERS*COORD_W-1:0]    lay_y_i,
  input  logic [NUM_LAYERS*COORD_W-1:0]    lay_w_i,
  input  logic [NUM_LAYERS*COORD_W-1:0]    lay_h_i,
  input  logic [NUM_LAYERS*PIX_W-1:0]      lay_pix_i,
  input  logic [NUM_LAYERS*CH_W-1:0]       lay_ga_i,
  input  logic [NUM_LAYERS-1:0]            lay_ga_en_i,
  input  logic                             pix_valid_i,
  input  logic [COORD_W-1:0]               x_i,
  input  logic [COORD_W-1:0]               y_i,
  output logic [RGB_W-1:0]                 rgb_o,
  output logic                             valid_o
);
  logic [NUM_LAYERS-1:0] hit;
  logic [CH_W-1:0]       eff_a [NUM_LAYERS];

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_lay
    layer_cover #(.COORD_W(COORD_W)) u_cov (
      .en_i        (lay_en_i[i]),
      .x_i         (x_i),
      .y_i         (y_i),
      .lx_i        (lay_x_i[i*COORD_W +: COORD_W]),
      .ly_i        (lay_y_i[i*COORD_W +: COORD_W]),
      .lw_i        (lay_w_i[i*COORD_W +: COORD_W]),
      .lh_i        (lay_h_i[i*COORD_W +: COORD_W]),
      .pix_alpha_i (lay_pix_i[i*PIX_W + RGB_W +: CH_W]),
      .ga_i        (lay_ga_i[i*CH_W +: CH_W]),
      .ga_en_i     (lay_ga_en_i[i]),
      .hit_o       (hit[i]),
      .alpha_o     (eff_a[i])
    );
  end

  logic              found [NUM_PIPES];
  logic [IDX_W-1:0]  win   [NUM_PIPES];
  logic [PRIO_W-1:0] wprio [NUM_PIPES];

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    pipe_arbiter #(.PIPE_ID(p)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit),
      .pipe_i  (lay_pipe_i),
      .prio_i  (lay_prio_i),
      .found_o (found[p]),
      .idx_o   (win[p]),
      .prio_o  (wprio[p])
    );
  end

  // stage 1: register pipe winners
  logic            in_ok;
  logic            ok_q, kill0_q;
  logic            found_q [NUM_PIPES];
  rgb_t            prgb_q  [NUM_PIPES];
  logic [CH_W-1:0] pa_q    [NUM_PIPES];
  rgb_t            bg_q;

  assign in_ok = pix_valid_i && (x_i < disp_w_i) && (y_i < disp_h_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q    <= 1'b0;
      kill0_q <= 1'b0;
      bg_q    <= '0;
      for (int p = 0; p < NUM_PIPES; p++) begin
        found_q[p] <= 1'b0;
        prgb_q[p]  <= '0;
        pa_q[p]    <= '0;
      end
    end else begin
      ok_q    <= in_ok;
      kill0_q <= defect_mode_i && found[0] && (wprio[0] == '0) &&
                 (eff_a[win[0]] != ALPHA_MAX);
      if (bg_we_i) bg_q <= bg_rgb_i;
      for (int p = 0; p < NUM_PIPES; p++) begin
        found_q[p] <= found[p];
        prgb_q[p]  <= lay_pix_i[win[p]*PIX_W +: RGB_W];
        pa_q[p]    <= eff_a[win[p]];
      end
    end
  end

  // stage 2: pipe 0 over background, pipe 1 over that
  rgb_t mix0, mix1, base, comp;

  blend_unit u_mix0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alpha_i (pa_q[0]),
    .fg_i    (prgb_q[0]),
    .bg_i    (bg_q),
    .mix_o   (mix0)
  );

  assign base = (found_q[0] && !kill0_q) ? mix0 : bg_q;

  blend_unit u_mix1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alpha_i (pa_q[1]),
    .fg_i    (prgb_q[1]),
    .bg_i    (base),
    .mix_o   (mix1)
  );

  assign comp = found_q[1] ? mix1 : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      rgb_o   <= ok_q ? comp : '0;
      valid_o <= ok_q;
    end
  end

  logic [1:0] arm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= {arm_q[0], 1'b1};
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q[1] |-> (valid_o == $past(in_ok, 2))); // R9
  AST_IDLE_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (rgb_o == '0)); // R8
  AST_BG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bg_we_i |=> $stable(bg_q)); // R10
  AST_DEFECT_BG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && kill0_q && !found_q[1]) |=> (rgb_o == $past(bg_q))); // R7
endmodule

// File: tb/tb_layer_compositor.sv
`timescale 1ns/1ps
module tb_layer_compositor;
  localparam int CW = 12;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            defect;
  logic            bg_we;
  logic [23:0]     bg_rgb;
  logic [CW-1:0]   disp_w, disp_h;
  logic [NL-1:0]   en, pipe, ga_en;
  logic [2*NL-1:0] prio;
  logic [NL*CW-1:0] lx, ly, lw, lh;
  logic [NL*32-1:0] pix;
  logic [NL*8-1:0]  ga;
  logic            pv;
  logic [CW-1:0]   xx, yy;
  logic [23:0]     rgb;
  logic            vld;

  layer_compositor #(.COORD_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .defect_mode_i(defect), .bg_we_i(bg_we),
    .bg_rgb_i(bg_rgb), .disp_w_i(disp_w), .disp_h_i(disp_h),
    .lay_en_i(en), .lay_pipe_i(pipe), .lay_prio_i(prio),
    .lay_x_i(lx), .lay_y_i(ly), .lay_w_i(lw), .lay_h_i(lh),
    .lay_pix_i(pix), .lay_ga_i(ga), .lay_ga_en_i(ga_en),
    .pix_valid_i(pv), .x_i(xx), .y_i(yy), .rgb_o(rgb), .valid_o(vld)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [23:0] bg_model = '0;

  function automatic int mix(int a, int f, int b);
    return (a * f + (255 - a) * b + 127) / 255;
  endfunction

  function automatic logic [23:0] mix_rgb(int a, logic [23:0] f, logic [23:0] b);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) r[c*8 +: 8] = 8'(mix(a, f[c*8 +: 8], b[c*8 +: 8]));
    return r;
  endfunction

  function automatic int eff_alpha(int i);
    int a = pix[i*32 + 24 +: 8];
    return ga_en[i] ? (a * ga[i*8 +: 8] + 127) / 255 : a;
  endfunction

  function automatic bit covers(int i, int x, int y);
    int x0 = lx[i*CW +: CW];
    int y0 = ly[i*CW +: CW];
    return en[i] && x >= x0 && x < x0 + int'(lw[i*CW +: CW]) &&
           y >= y0 && y < y0 + int'(lh[i*CW +: CW]);
  endfunction

  function automatic logic [23:0] ref_rgb(int x, int y, bit ok);
    int best [2];
    logic [23:0] c0;
    if (!ok) return '0;
    best[0] = -1; best[1] = -1;
    for (int i = 0; i < NL; i++) begin
      if (covers(i, x, y)) begin
        int p = pipe[i];
        if (best[p] < 0 || prio[i*2 +: 2] >= prio[best[p]*2 +: 2]) best[p] = i;
      end
    end
    if (best[0] < 0) c0 = bg_model;
    else if (defect && prio[best[0]*2 +: 2] == 0 && eff_alpha(best[0]) < 255) c0 = bg_model;
    else c0 = mix_rgb(eff_alpha(best[0]), pix[best[0]*32 +: 24], bg_model);
    if (best[1] < 0) return c0;
    return mix_rgb(eff_alpha(best[1]), pix[best[1]*32 +: 24], c0);
  endfunction

  task automatic set_layer(int i, bit e, bit p, int pr, int x, int y, int w, int h,
                           logic [31:0] px, int g, bit ge);
    en[i] = e; pipe[i] = p; prio[i*2 +: 2] = 2'(pr);
    lx[i*CW +: CW] = CW'(x); ly[i*CW +: CW] = CW'(y);
    lw[i*CW +: CW] = CW'(w); lh[i*CW +: CW] = CW'(h);
    pix[i*32 +: 32] = px; ga[i*8 +: 8] = 8'(g); ga_en[i] = ge;
  endtask

  task automatic clear_layers();
    for (int i = 0; i < NL; i++) set_layer(i, 0, 0, 0, 0, 0, 0, 0, 32'h0, 255, 0);
  endtask

  task automatic cmp(string tag, int x, int y, logic [23:0] act, logic [23:0] exp,
                     logic av, logic ev);
    checks++;
    if (act !== exp || av !== ev) begin
      fails++;
      $display("FAIL %s x=%0d y=%0d: rgb act=%h exp=%h valid act=%b exp=%b",
               tag, x, y, act, exp, av, ev);
    end
  endtask

  // expected from the model, optionally cross-checked against a fixed value
  task automatic probe(string tag, int x, int y, bit p_valid, bit use_fix, logic [23:0] fix);
    bit ok;
    logic [23:0] e;
    pv = p_valid; xx = CW'(x); yy = CW'(y);
    ok = p_valid && x < int'(disp_w) && y < int'(disp_h);
    e = use_fix ? fix : ref_rgb(x, y, ok);
    @(posedge clk); @(posedge clk); #1;
    cmp(tag, x, y, rgb, e, vld, ok);
  endtask

  task automatic load_bg(logic [23:0] v);
    bg_we = 1; bg_rgb = v;
    @(posedge clk); #1;
    bg_we = 0; bg_model = v;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    defect = 0; bg_we = 0; bg_rgb = '0; disp_w = CW'(24); disp_h = CW'(24);
    pv = 0; xx = '0; yy = '0;
    clear_layers();
    #12;
    cmp("R1 reset", 0, 0, rgb, 24'h0, vld, 1'b0);
    rst_n = 1;
    @(posedge clk); #1;

    // R1: background black after reset
    probe("R1 bg black", 3, 3, 1, 1, 24'h000000);

    // R10/R5: loaded background shows where nothing covers
    load_bg(24'h123456);
    probe("R10 bg load", 5, 5, 1, 1, 24'h123456);
    bg_rgb = 24'hffffff;
    @(posedge clk); #1;
    probe("R10 bg hold", 5, 5, 1, 1, 24'h123456);

    // R2: rectangle edges
    set_layer(0, 1, 0, 0, 4, 2, 3, 2, 32'hff_ff0000, 255, 0);
    probe("R2 left out", 3, 2, 1, 1, 24'h123456);
    probe("R2 left in",  4, 2, 1, 1, 24'hff0000);
    probe("R2 right in", 6, 3, 1, 1, 24'hff0000);
    probe("R2 right out", 7, 2, 1, 1, 24'h123456);
    probe("R2 bottom out", 5, 4, 1, 1, 24'h123456);
    en[0] = 0;
    probe("R2 disabled", 5, 2, 1, 1, 24'h123456);
    set_layer(0, 1, 0, 0, 4, 2, 0, 2, 32'hff_ff0000, 255, 0);
    probe("R2 zero width", 4, 2, 1, 1, 24'h123456);

    // R3: priority then tie
    clear_layers();
    set_layer(0, 1, 0, 2, 0, 0, 10, 10, 32'hff_00ff00, 255, 0);
    set_layer(1, 1, 0, 1, 0, 0, 10, 10, 32'hff_0000ff, 255, 0);
    probe("R3 higher prio", 2, 2, 1, 1, 24'h00ff00);
    prio[3:2] = 2'd2;
    probe("R3 tie higher index", 2, 2, 1, 1, 24'h0000ff);
    prio[3:2] = 2'd3;
    set_layer(2, 1, 1, 0, 20, 20, 2, 2, 32'hff_ffffff, 255, 0);
    probe("R3 other pipe ignored", 2, 2, 1, 1, 24'h0000ff);

    // R4: pipe 1 over pipe 0
    clear_layers();
    load_bg(24'h000000);
    set_layer(0, 1, 0, 3, 0, 0, 10, 10, 32'hff_204060, 255, 0);
    set_layer(3, 1, 1, 0, 0, 0, 10, 10, 32'h80_e0a010, 255, 0);
    probe("R4 half blend", 1, 1, 1, 1,
          {8'(mix(128, 8'he0, 8'h20)), 8'(mix(128, 8'ha0, 8'h40)), 8'(mix(128, 8'h10, 8'h60))});
    pix[3*32 + 24 +: 8] = 8'h00;
    probe("R4 transparent top", 1, 1, 1, 1, 24'h204060);
    pix[3*32 + 24 +: 8] = 8'hff;
    probe("R4 opaque top", 1, 1, 1, 1, 24'he0a010);

    // R5: pipe 0 translucent over background
    clear_layers();
    load_bg(24'h0000ff);
    set_layer(1, 1, 0, 1, 0, 0, 8, 8, 32'h40_ff0000, 255, 0);
    probe("R5 pipe0 over bg", 2, 2, 1, 1,
          {8'(mix(64, 255, 0)), 8'h00, 8'(mix(64, 0, 255))});

    // R6: global alpha scales pixel alpha
    set_layer(1, 1, 0, 1, 0, 0, 8, 8, 32'hff_ff0000, 64, 1);
    probe("R6 global alpha", 2, 2, 1, 1,
          {8'(mix(64, 255, 0)), 8'h00, 8'(mix(64, 0, 255))});
    set_layer(1, 1, 0, 1, 0, 0, 8, 8, 32'hff_ff0000, 64, 0);
    probe("R6 global alpha off", 2, 2, 1, 1, 24'hff0000);

    // R7: defect mode on lowest pipe-0 layer
    clear_layers();
    load_bg(24'h101010);
    set_layer(0, 1, 0, 0, 0, 0, 8, 8, 32'hc8_f0f0f0, 255, 0);
    defect = 1;
    probe("R7 defect bg", 2, 2, 1, 1, 24'h101010);
    defect = 0;
    probe("R7 defect off", 2, 2, 1, 0, '0);
    defect = 1;
    pix[31:24] = 8'hff;
    probe("R7 opaque kept", 2, 2, 1, 1, 24'hf0f0f0);
    pix[31:24] = 8'hc8;
    prio[1:0] = 2'd1;
    probe("R7 prio1 kept", 2, 2, 1, 0, '0);
    defect = 0;

    // R8: display bounds
    probe("R8 last column", 23, 0, 1, 0, '0);
    probe("R8 past width", 24, 0, 1, 1, 24'h000000);
    probe("R8 past height", 0, 24, 1, 1, 24'h000000);
    probe("R8 not valid", 2, 2, 0, 1, 24'h000000);

    // R9: two-cycle latency
    pv = 0;
    repeat (3) @(posedge clk);
    #1;
    pv = 1; xx = CW'(2); yy = CW'(2);
    @(posedge clk); #1;
    cmp("R9 one edge", 2, 2, rgb, 24'h0, vld, 1'b0);
    @(posedge clk); #1;
    cmp("R9 two edges", 2, 2, rgb, ref_rgb(2, 2, 1), vld, 1'b1);

    // random scenes
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < NL; i++) begin
        int r = $urandom % 3;
        logic [31:0] px = $urandom;
        if (r == 0) px[31:24] = 8'hff;
        else if (r == 1) px[31:24] = 8'h00;
        set_layer(i, ($urandom % 4) != 0, $urandom % 2, $urandom % 4,
                  $urandom % 20, $urandom % 20, $urandom % 16, $urandom % 16,
                  px, $urandom % 256, ($urandom % 3) == 0);
      end
      defect = ($urandom % 2) == 1;
      if (t % 50 == 0) load_bg(24'($urandom));
      for (int k = 0; k < 4; k++)
        probe("R4 random", $urandom % 28, $urandom % 28, ($urandom % 8) != 0, 0, '0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule